// File: doc/BRIEF.md
# Tag-Matching Reservation Station Pool

This block holds operations for one class of functional unit in an out-of-order floating-point core. Each operation waits here until both of its source operands are known. The issue stage delivers an operation with two sources. A source either comes as a value that is ready now, or as the tag of the station that will later produce that value. A tag of zero means there is no pending producer. The slots in the pool are numbered from one, and each slot's number is its own station tag.

While an operand is pending, its slot watches a shared result broadcast bus. The bus carries a value and the tag of the station that produced it. When both operands of a slot have arrived, the slot can be dispatched. Among the slots that can be dispatched, the oldest is sent first, at most one per cycle, and it goes to the execution unit together with its own tag. A dispatched slot stays occupied until its own tag appears on the broadcast bus. That broadcast frees the slot for a new operation.

Top module: `rs_pool`

## Requirements
- R1: After reset every slot is free: `iss_ready_o` is 1 and `disp_valid_o` is 0.
- R2: `iss_ready_o` is 1 exactly when at least one slot is free. An issue offered while it is 0 is dropped: it takes no slot and is never dispatched.
- R3: An accepted issue takes the lowest-numbered free slot. Slot k (counted from 0) carries tag k+1, and that tag is shown on `iss_tag_o` while `iss_ready_o` is 1.
- R4: An issued source with tag 0 is taken as a ready value. A source with a nonzero tag waits for that producer, and the slot cannot be dispatched while it waits.
- R5: If a source tag equals the tag on a valid broadcast in the same cycle as the issue, the slot stores the broadcast value and the source is ready at once.
- R6: A valid broadcast with tag T gives its value to every waiting operand whose producer tag is T. A slot whose last operand is filled this way can be dispatched from the next cycle.
- R7: A slot is dispatched once, only when both operands are ready, and never again. At most one dispatch happens per cycle, and it carries the slot's opcode, both operand values and its tag.
- R8: When several slots can be dispatched in the same cycle, the slot issued earliest goes first, whatever its slot number.
- R9: A valid broadcast whose tag equals the tag of a dispatched slot frees that slot from the next cycle on. A broadcast tag that names no dispatched slot in this pool frees nothing.
- R10: While `res_valid_i` is 0, no operand is captured and no slot is freed, whatever tag and value are on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid_i | input | 1 | Issue request |
| iss_ready_o | output | 1 | A free slot exists; the issue is accepted when this and valid are both 1 |
| iss_op_i | input | OP_W | Opcode of the issued operation |
| iss_src1_tag_i | input | TAG_W | Producer tag of source 1, 0 when the value is ready |
| iss_src1_val_i | input | DATA_W | Value of source 1 when its tag is 0 |
| iss_src2_tag_i | input | TAG_W | Producer tag of source 2, 0 when the value is ready |
| iss_src2_val_i | input | DATA_W | Value of source 2 when its tag is 0 |
| iss_tag_o | output | TAG_W | Tag of the slot the next accepted issue will take |
| res_valid_i | input | 1 | Broadcast bus carries a result |
| res_tag_i | input | TAG_W | Tag of the station that produced the result |
| res_val_i | input | DATA_W | Result value |
| disp_valid_o | output | 1 | A slot is dispatched this cycle |
| disp_tag_o | output | TAG_W | Tag of the dispatched slot |
| disp_op_o | output | OP_W | Opcode of the dispatched slot |
| disp_src1_o | output | DATA_W | Source 1 value of the dispatched slot |
| disp_src2_o | output | DATA_W | Source 2 value of the dispatched slot |

## Verification
The directed patterns cover the following cases, and each one separates a correct design from a specific fault:
- Issue with both sources ready, and issue with a source waiting on another slot: these tell dispatch-on-ready apart from dispatch-on-issue.
- A single broadcast that both completes a producer and wakes its consumer: this checks that freeing and capture happen in the same step.
- An issue that meets its producer's broadcast in the same cycle: this catches a lost wakeup.
- Broadcasts with external tags or with `res_valid_i` low: these show that only the right events free a slot.
- Slot reuse, so that a young operation sits in slot 0 behind older ones in higher slots, followed by one broadcast that wakes them all together: this tells oldest-first selection apart from lowest-index selection.

A long randomized phase then runs the bench as the execution unit. It returns results after varying delays, mixes in foreign-tag broadcasts, and issues sources that depend on slots still in flight. A behavioural model compares readiness, allocation tag and every dispatch field in every cycle.

// File: rtl/rsp_pkg.sv
`timescale 1ns/1ps
package rsp_pkg;

  // widest tag the helper functions accept
  localparam int TAG_MAX_W = 16;

  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_WAIT = 2'd1,
    SLOT_SENT = 2'd2
  } slot_st_e;

  // a broadcast hits a wanted producer tag; tag zero never matches
  function automatic logic tag_match(input logic                 vld,
                                     input logic [TAG_MAX_W-1:0] bus_tag,
                                     input logic [TAG_MAX_W-1:0] want);
    return vld && (want != '0) && (bus_tag == want);
  endfunction

  // station tag of slot idx, slots numbered upward from base
  function automatic int unsigned slot_tag(input int unsigned idx,
                                           input int unsigned base);
    return idx + base;
  endfunction

endpackage

// File: rtl/rsp_slot.sv
`timescale 1ns/1ps
module rsp_slot
  import rsp_pkg::*;
#(
  parameter int OP_W   = 4,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 3,
  parameter int MY_TAG = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_val_i,
  input  logic [TAG_W-1:0]  a_tag_i,
  input  logic              a_rdy_i,
  input  logic [DATA_W-1:0] b_val_i,
  input  logic [TAG_W-1:0]  b_tag_i,
  input  logic              b_rdy_i,
  input  logic              bus_vld_i,
  input  logic [TAG_W-1:0]  bus_tag_i,
  input  logic [DATA_W-1:0] bus_val_i,
  input  logic              pick_i,
  output logic              busy_o,
  output logic              elig_o,
  output logic              done_o,
  output logic [OP_W-1:0]   op_o,
  output logic [DATA_W-1:0] a_val_o,
  output logic [DATA_W-1:0] b_val_o
);

  localparam logic [TAG_W-1:0] OWN_TAG = TAG_W'(MY_TAG);

  slot_st_e          st_q;
  logic [OP_W-1:0]   op_q;
  logic [DATA_W-1:0] a_val_q, b_val_q;
  logic [TAG_W-1:0]  a_tag_q, b_tag_q;
  logic              a_rdy_q, b_rdy_q;

  // named wakeup and completion events
  logic a_wake, b_wake, done_hit;

  assign a_wake = (st_q == SLOT_WAIT) && !a_rdy_q &&
                  tag_match(bus_vld_i, TAG_MAX_W'(bus_tag_i), TAG_MAX_W'(a_tag_q));
  assign b_wake = (st_q == SLOT_WAIT) && !b_rdy_q &&
                  tag_match(bus_vld_i, TAG_MAX_W'(bus_tag_i), TAG_MAX_W'(b_tag_q));
  assign done_hit = (st_q == SLOT_SENT) && bus_vld_i && (bus_tag_i == OWN_TAG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= SLOT_IDLE;
      op_q    <= '0;
      a_val_q <= '0;
      b_val_q <= '0;
      a_tag_q <= '0;
      b_tag_q <= '0;
      a_rdy_q <= 1'b0;
      b_rdy_q <= 1'b0;
    end else if (alloc_i) begin
      st_q    <= SLOT_WAIT;
      op_q    <= op_i;
      a_val_q <= a_val_i;
      b_val_q <= b_val_i;
      a_tag_q <= a_tag_i;
      b_tag_q <= b_tag_i;
      a_rdy_q <= a_rdy_i;
      b_rdy_q <= b_rdy_i;
    end else begin
      if (done_hit) begin
        st_q <= SLOT_IDLE;
      end else if (pick_i) begin
        st_q <= SLOT_SENT;
      end
      if (a_wake) begin
        a_val_q <= bus_val_i;
        a_rdy_q <= 1'b1;
      end
      if (b_wake) begin
        b_val_q <= bus_val_i;
        b_rdy_q <= 1'b1;
      end
    end
  end

  assign busy_o  = (st_q != SLOT_IDLE);
  assign elig_o  = (st_q == SLOT_WAIT) && a_rdy_q && b_rdy_q;
  assign done_o  = done_hit;
  assign op_o    = op_q;
  assign a_val_o = a_val_q;
  assign b_val_o = b_val_q;

endmodule

// File: rtl/rsp_free_find.sv
`timescale 1ns/1ps
module rsp_free_find #(
  parameter int N = 4
) (
  input  logic [N-1:0] busy_i,
  output logic [N-1:0] first_oh_o,
  output logic         any_o
);

  logic found;

  always_comb begin
    found      = 1'b0;
    first_oh_o = '0;
    for (int i = 0; i < N; i++) begin
      if (!busy_i[i] && !found) begin
        first_oh_o[i] = 1'b1;
        found         = 1'b1;
      end
    end
  end

  assign any_o = ~&busy_i;

endmodule

// File: rtl/rsp_age_pick.sv
`timescale 1ns/1ps
module rsp_age_pick #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] alloc_oh_i,
  input  logic [N-1:0] elig_i,
  output logic [N-1:0] pick_oh_o,
  output logic         pick_any_o
);

  // older_q[i][j] is set when slot i was issued before slot j
  logic [N-1:0] older_q [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) older_q[i] <= '0;
    end else if (|alloc_oh_i) begin
      for (int i = 0; i < N; i++) begin
        if (alloc_oh_i[i]) older_q[i] <= '0;
        else               older_q[i] <= older_q[i] | alloc_oh_i;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      pick_oh_o[i] = elig_i[i];
      for (int j = 0; j < N; j++) begin
        if (j != i && elig_i[j] && older_q[j][i]) pick_oh_o[i] = 1'b0;
      end
    end
  end

  assign pick_any_o = |pick_oh_o;

endmodule

// File: rtl/rs_pool.sv
`timescale 1ns/1ps
module rs_pool
  import rsp_pkg::*;
#(
  parameter int NUM_ENT  = 4,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 3,
  parameter int OP_W     = 4,
  parameter int BASE_TAG = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid_i,
  output logic              iss_ready_o,
  input  logic [OP_W-1:0]   iss_op_i,
  input  logic [TAG_W-1:0]  iss_src1_tag_i,
  input  logic [DATA_W-1:0] iss_src1_val_i,
  input  logic [TAG_W-1:0]  iss_src2_tag_i,
  input  logic [DATA_W-1:0] iss_src2_val_i,
  output logic [TAG_W-1:0]  iss_tag_o,
  input  logic              res_valid_i,
  input  logic [TAG_W-1:0]  res_tag_i,
  input  logic [DATA_W-1:0] res_val_i,
  output logic              disp_valid_o,
  output logic [TAG_W-1:0]  disp_tag_o,
  output logic [OP_W-1:0]   disp_op_o,
  output logic [DATA_W-1:0] disp_src1_o,
  output logic [DATA_W-1:0] disp_src2_o
);

  // named internal events
  logic [NUM_ENT-1:0] busy_vec;
  logic [NUM_ENT-1:0] elig_vec;
  logic [NUM_ENT-1:0] done_vec;
  logic [NUM_ENT-1:0] first_free_oh;
  logic [NUM_ENT-1:0] alloc_oh;
  logic [NUM_ENT-1:0] pick_oh;
  logic               any_free;
  logic               iss_fire;
  logic               pick_any;

  logic [OP_W-1:0]    op_arr [NUM_ENT];
  logic [DATA_W-1:0]  a_arr  [NUM_ENT];
  logic [DATA_W-1:0]  b_arr  [NUM_ENT];

  // issue-side operand resolution, including same-cycle broadcast capture
  logic               src1_rdy, src2_rdy;
  logic [DATA_W-1:0]  src1_val, src2_val;
  logic [TAG_W-1:0]   src1_tag, src2_tag;

  always_comb begin
    src1_rdy = (iss_src1_tag_i == '0) ||
               tag_match(res_valid_i, TAG_MAX_W'(res_tag_i), TAG_MAX_W'(iss_src1_tag_i));
    src2_rdy = (iss_src2_tag_i == '0) ||
               tag_match(res_valid_i, TAG_MAX_W'(res_tag_i), TAG_MAX_W'(iss_src2_tag_i));
    src1_val = (iss_src1_tag_i == '0) ? iss_src1_val_i : res_val_i;
    src2_val = (iss_src2_tag_i == '0) ? iss_src2_val_i : res_val_i;
    src1_tag = src1_rdy ? '0 : iss_src1_tag_i;
    src2_tag = src2_rdy ? '0 : iss_src2_tag_i;
  end

  rsp_free_find #(.N(NUM_ENT)) free_find_i (
    .busy_i     (busy_vec),
    .first_oh_o (first_free_oh),
    .any_o      (any_free)
  );

  assign iss_ready_o = any_free;
  assign iss_fire    = iss_valid_i && any_free;
  assign alloc_oh    = iss_fire ? first_free_oh : '0;

  always_comb begin
    iss_tag_o = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (first_free_oh[i]) iss_tag_o = TAG_W'(slot_tag(i, BASE_TAG));
    end
  end

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_slot
    rsp_slot #(
      .OP_W   (OP_W),
      .DATA_W (DATA_W),
      .TAG_W  (TAG_W),
      .MY_TAG (BASE_TAG + g)
    ) slot_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc_i   (alloc_oh[g]),
      .op_i      (iss_op_i),
      .a_val_i   (src1_val),
      .a_tag_i   (src1_tag),
      .a_rdy_i   (src1_rdy),
      .b_val_i   (src2_val),
      .b_tag_i   (src2_tag),
      .b_rdy_i   (src2_rdy),
      .bus_vld_i (res_valid_i),
      .bus_tag_i (res_tag_i),
      .bus_val_i (res_val_i),
      .pick_i    (pick_oh[g]),
      .busy_o    (busy_vec[g]),
      .elig_o    (elig_vec[g]),
      .done_o    (done_vec[g]),
      .op_o      (op_arr[g]),
      .a_val_o   (a_arr[g]),
      .b_val_o   (b_arr[g])
    );
  end

  rsp_age_pick #(.N(NUM_ENT)) age_pick_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_oh_i (alloc_oh),
    .elig_i     (elig_vec),
    .pick_oh_o  (pick_oh),
    .pick_any_o (pick_any)
  );

  // one-hot and-or dispatch mux
  always_comb begin
    disp_tag_o  = '0;
    disp_op_o   = '0;
    disp_src1_o = '0;
    disp_src2_o = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (pick_oh[i]) begin
        disp_tag_o  = disp_tag_o  | TAG_W'(slot_tag(i, BASE_TAG));
        disp_op_o   = disp_op_o   | op_arr[i];
        disp_src1_o = disp_src1_o | a_arr[i];
        disp_src2_o = disp_src2_o | b_arr[i];
      end
    end
  end

  assign disp_valid_o = pick_any;

endmodule

// File: rtl/rs_pool_chk.sv
`timescale 1ns/1ps
module rs_pool_chk #(
  parameter int N     = 4,
  parameter int TAG_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iss_ready,
  input logic             iss_fire,
  input logic [N-1:0]     alloc_oh,
  input logic [N-1:0]     busy_vec,
  input logic [N-1:0]     pick_oh,
  input logic             disp_valid,
  input logic [TAG_W-1:0] disp_tag,
  input logic [N-1:0]     done_vec,
  input logic             res_valid
);

  // R2
  full_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_ready |-> (alloc_oh == '0));

  // R3
  alloc_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_fire |=> ((busy_vec & $past(alloc_oh)) == $past(alloc_oh)));

  // R7
  single_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick_oh));

  // R7
  sent_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |=> ((pick_oh & $past(pick_oh)) == '0));

  // R7
  disp_tag_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (disp_tag != '0));

  // R9
  freed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|done_vec) |=> ((busy_vec & $past(done_vec)) == '0));

  // R10
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (done_vec == '0));

endmodule

bind rs_pool rs_pool_chk #(.N(NUM_ENT), .TAG_W(TAG_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .iss_ready  (iss_ready_o),
  .iss_fire   (iss_fire),
  .alloc_oh   (alloc_oh),
  .busy_vec   (busy_vec),
  .pick_oh    (pick_oh),
  .disp_valid (disp_valid_o),
  .disp_tag   (disp_tag_o),
  .done_vec   (done_vec),
  .res_valid  (res_valid_i)
);

// File: tb/rs_pool_tb_top.sv
`timescale 1ns/1ps
module rs_pool_tb_top;

  localparam int NE = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        iss_valid;
  logic        iss_ready;
  logic [3:0]  iss_op;
  logic [2:0]  iss_t1, iss_t2, iss_tag;
  logic [31:0] iss_v1, iss_v2;
  logic        res_valid;
  logic [2:0]  res_tag;
  logic [31:0] res_val;
  logic        disp_valid;
  logic [2:0]  disp_tag;
  logic [3:0]  disp_op;
  logic [31:0] disp_a, disp_b;

  always #2.5 clk = ~clk;

  rs_pool dut_i (
    .clk(clk), .rst_n(rst_n),
    .iss_valid_i(iss_valid), .iss_ready_o(iss_ready), .iss_op_i(iss_op),
    .iss_src1_tag_i(iss_t1), .iss_src1_val_i(iss_v1),
    .iss_src2_tag_i(iss_t2), .iss_src2_val_i(iss_v2),
    .iss_tag_o(iss_tag),
    .res_valid_i(res_valid), .res_tag_i(res_tag), .res_val_i(res_val),
    .disp_valid_o(disp_valid), .disp_tag_o(disp_tag), .disp_op_o(disp_op),
    .disp_src1_o(disp_a), .disp_src2_o(disp_b)
  );

  int total = 0;
  int bad   = 0;
  int cycle_no = 0;
  bit auto_exec = 1'b0;

  // behavioural model: 0 free, 1 waiting, 2 dispatched
  int          m_st [NE];
  int          m_op [NE];
  logic [31:0] m_a  [NE];
  logic [31:0] m_b  [NE];
  int          m_qa [NE];
  int          m_qb [NE];
  int          m_sq [NE];
  int          seq_ctr = 0;

  // bench acting as execution unit
  int          x_tag [$];
  int          x_due [$];
  logic [31:0] x_val [$];
  int          last_due = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic model_expect(output bit er, output int k, output bit ed, output int p);
    er = 1'b0; k = 0; ed = 1'b0; p = 0;
    for (int i = NE - 1; i >= 0; i--) if (m_st[i] == 0) begin er = 1'b1; k = i; end
    for (int i = 0; i < NE; i++) begin
      if (m_st[i] == 1 && m_qa[i] == 0 && m_qb[i] == 0 && (!ed || m_sq[i] < m_sq[p])) begin
        ed = 1'b1; p = i;
      end
    end
  endtask

  task automatic cyc(input bit iv, input int op, input int t1, input logic [31:0] v1,
                     input int t2, input logic [31:0] v2,
                     input bit rv, input int rt, input logic [31:0] rval);
    bit er, ed;
    int k, p;
    @(negedge clk);
    iss_valid = iv; iss_op = 4'(op);
    iss_t1 = 3'(t1); iss_v1 = v1; iss_t2 = 3'(t2); iss_v2 = v2;
    res_valid = rv; res_tag = 3'(rt); res_val = rval;
    #1;
    model_expect(er, k, ed, p);
    chk(iss_ready == er, "R2", "iss_ready", iss_ready, er);
    if (er) chk(int'(iss_tag) == k + 1, "R3", "iss_tag", iss_tag, k + 1);
    chk(disp_valid == ed, "R7", "disp_valid", disp_valid, ed);
    if (ed) begin
      chk(int'(disp_tag) == p + 1, "R8", "disp_tag", disp_tag, p + 1);
      chk(disp_a == m_a[p], "R6", "disp_src1", disp_a, m_a[p]);
      chk(disp_b == m_b[p], "R6", "disp_src2", disp_b, m_b[p]);
      chk(int'(disp_op) == m_op[p], "R7", "disp_op", disp_op, m_op[p]);
      if (auto_exec) begin
        int due;
        due = cycle_no + 1 + int'($urandom % 4);
        if (due <= last_due) due = last_due + 1;
        last_due = due;
        x_tag.push_back(p + 1);
        x_due.push_back(due);
        x_val.push_back(m_a[p] + m_b[p] + 32'(m_op[p]));
      end
    end
    // broadcast effects on existing slots
    if (rv) begin
      for (int i = 0; i < NE; i++) begin
        if (m_st[i] == 1) begin
          if (m_qa[i] != 0 && m_qa[i] == rt) begin m_a[i] = rval; m_qa[i] = 0; end
          if (m_qb[i] != 0 && m_qb[i] == rt) begin m_b[i] = rval; m_qb[i] = 0; end
        end else if (m_st[i] == 2 && rt == i + 1) begin
          m_st[i] = 0;
        end
      end
    end
    if (ed) m_st[p] = 2;
    if (iv && er) begin
      m_st[k] = 1; m_op[k] = op; m_sq[k] = seq_ctr; seq_ctr++;
      if (t1 == 0) begin m_a[k] = v1; m_qa[k] = 0; end
      else if (rv && rt == t1) begin m_a[k] = rval; m_qa[k] = 0; end
      else begin m_a[k] = '0; m_qa[k] = t1; end
      if (t2 == 0) begin m_b[k] = v2; m_qb[k] = 0; end
      else if (rv && rt == t2) begin m_b[k] = rval; m_qb[k] = 0; end
      else begin m_b[k] = '0; m_qb[k] = t2; end
    end
    cycle_no++;
    @(posedge clk);
  endtask

  task automatic idle();
    cyc(1'b0, 0, 0, '0, 0, '0, 1'b0, 0, '0);
  endtask

  task automatic bcast(input int t, input logic [31:0] v);
    cyc(1'b0, 0, 0, '0, 0, '0, 1'b1, t, v);
  endtask

  task automatic expect_disp(input bit v, input int tag, input logic [31:0] a,
                             input logic [31:0] b, input string req);
    #1;
    chk(disp_valid == v, req, "disp_valid", disp_valid, v);
    if (v) begin
      chk(int'(disp_tag) == tag, req, "disp_tag", disp_tag, tag);
      chk(disp_a == a, req, "disp_src1", disp_a, a);
      chk(disp_b == b, req, "disp_src2", disp_b, b);
    end
  endtask

  task automatic expect_tag(input int tag, input string req);
    #1;
    chk(iss_ready == 1'b1, req, "iss_ready", iss_ready, 1);
    chk(int'(iss_tag) == tag, req, "iss_tag", iss_tag, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R7 watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NE; i++) begin
      m_st[i] = 0; m_op[i] = 0; m_a[i] = '0; m_b[i] = '0;
      m_qa[i] = 0; m_qb[i] = 0; m_sq[i] = 0;
    end
    rst_n = 1'b0; iss_valid = 1'b0; iss_op = '0;
    iss_t1 = '0; iss_t2 = '0; iss_v1 = '0; iss_v2 = '0;
    res_valid = 1'b0; res_tag = '0; res_val = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(iss_ready == 1'b1, "R1", "iss_ready", iss_ready, 1);
    chk(disp_valid == 1'b0, "R1", "disp_valid", disp_valid, 0);
    chk(iss_tag == 3'd1, "R1", "iss_tag", iss_tag, 1);

    // R4 both sources ready
    cyc(1'b1, 1, 0, 32'd100, 0, 32'd200, 1'b0, 0, '0);
    expect_disp(1'b1, 1, 32'd100, 32'd200, "R4");
    idle();
    expect_disp(1'b0, 0, '0, '0, "R7");
    // R4 source waits on slot 1
    cyc(1'b1, 2, 1, 32'hdead, 0, 32'd7, 1'b0, 0, '0);
    expect_disp(1'b0, 0, '0, '0, "R4");
    // R6 / R9 one broadcast frees producer and wakes consumer
    bcast(1, 32'd55);
    expect_disp(1'b1, 2, 32'd55, 32'd7, "R6");
    expect_tag(1, "R9");
    idle();
    // R5 same-cycle capture at issue
    cyc(1'b1, 3, 6, 32'hbad, 0, 32'd9, 1'b1, 6, 32'd77);
    expect_disp(1'b1, 1, 32'd77, 32'd9, "R5");
    idle();
    // R10 invalid bus frees nothing
    cyc(1'b0, 0, 0, '0, 0, '0, 1'b0, 2, 32'h1234);
    expect_tag(3, "R10");
    // R9 foreign tag frees nothing, own tags free
    bcast(5, 32'd1);
    expect_tag(3, "R9");
    bcast(2, 32'd2);
    expect_tag(2, "R9");
    bcast(1, 32'd3);
    expect_tag(1, "R9");

    // R8 age order differs from slot order
    cyc(1'b1, 4, 0, 32'd11, 0, 32'd12, 1'b0, 0, '0);
    cyc(1'b1, 5, 7, '0, 0, 32'd21, 1'b0, 0, '0);
    cyc(1'b1, 6, 7, '0, 0, 32'd31, 1'b0, 0, '0);
    bcast(1, 32'd0);
    cyc(1'b1, 7, 7, '0, 0, 32'd41, 1'b0, 0, '0);
    cyc(1'b1, 8, 0, 32'd51, 0, 32'd52, 1'b1, 7, 32'h70);
    expect_disp(1'b1, 2, 32'h70, 32'd21, "R8");
    chk(iss_ready == 1'b0, "R2", "iss_ready full", iss_ready, 0);
    cyc(1'b1, 9, 0, 32'd1, 0, 32'd2, 1'b0, 0, '0);
    expect_disp(1'b1, 3, 32'h70, 32'd31, "R8");
    idle();
    expect_disp(1'b1, 1, 32'h70, 32'd41, "R8");
    idle();
    expect_disp(1'b1, 4, 32'd51, 32'd52, "R8");
    idle();
    expect_disp(1'b0, 0, '0, '0, "R2");
    bcast(1, '0); bcast(2, '0); bcast(3, '0); bcast(4, '0);
    expect_tag(1, "R9");

    // randomized traffic, bench as execution unit
    auto_exec = 1'b1;
    for (int n = 0; n < 3200; n++) begin
      bit iv, rv;
      int rt, t1, t2;
      logic [31:0] rval;
      int live [$];
      iv = (n < 3000) && ($urandom % 10 < 6);
      if (x_due.size() > 0 && x_due[0] <= cycle_no) begin
        rv = 1'b1; rt = x_tag.pop_front(); rval = x_val.pop_front();
        void'(x_due.pop_front());
      end else if ($urandom % 5 == 0) begin
        rv = 1'b1; rt = ($urandom % 4 == 0) ? 0 : 5 + int'($urandom % 3); rval = $urandom;
      end else begin
        rv = 1'b0; rt = int'($urandom % 8); rval = $urandom;
      end
      for (int i = 0; i < NE; i++) if (m_st[i] != 0) live.push_back(i + 1);
      t1 = 0; t2 = 0;
      case ($urandom % 10)
        0, 1, 2, 3: t1 = 0;
        4, 5, 6:    t1 = (live.size() > 0) ? live[$urandom % live.size()] : 0;
        default:    t1 = 5 + int'($urandom % 3);
      endcase
      case ($urandom % 10)
        0, 1, 2, 3: t2 = 0;
        4, 5, 6:    t2 = (live.size() > 0) ? live[$urandom % live.size()] : 0;
        default:    t2 = 5 + int'($urandom % 3);
      endcase
      cyc(iv, int'($urandom % 16), t1, $urandom, t2, $urandom, rv, rt, rval);
    end
    finish_run();
  end

endmodule